// File: doc/BRIEF.md
# Half-Precision Add/Subtract Special-Case Front End

This block sits at the input of a 16-bit floating-point add/subtract unit. Each operand has a sign bit, a 5-bit exponent and a 10-bit fraction. The block sorts each operand into one of five kinds: zero, subnormal, normal, infinity or NaN.

When the answer follows from the operand kinds alone, the block drives that answer on its result port. When both operands are ordinary finite nonzero values, it raises a start flag instead, and the alignment, add and normalization stages downstream take over.

The block is purely combinational. A subtract request is folded into the sign of the second operand before any decision is made. Every later rule therefore sees one effective addition.

Top module: `hp_special_front`

## Requirements
- R1: Each operand is classified from its exponent field (bits 14:10) and fraction field (bits 9:0):
  - exponent 0 with fraction 0 is zero;
  - exponent 0 with a nonzero fraction is subnormal;
  - any exponent from 1 to 30 is normal, whatever the fraction (so 0x3C00 is normal);
  - exponent 31 with fraction 0 is infinity;
  - exponent 31 with a nonzero fraction is NaN.
- R2: `arith_go` is 1 exactly when both operands are normal or subnormal.
- R3: When `op_sub` is 1, bit 15 of `op_b` is inverted before any classification or selection. For example, 0 − 0x3C00 gives 0xBC00.
- R4: If either operand is NaN, the result is 0x7E00 and `arith_go` is 0. This rule outranks all others.
- R5: Two infinities whose signs differ after the R3 adjustment give 0x7E00.
- R6: An infinity paired with a finite operand, or with an infinity of the same effective sign, gives that infinity with its own sign.
- R7: If A is zero and B is finite, the result is the sign-adjusted B.
- R8: If B is zero and A is finite and nonzero, the result is A unchanged.
- R9: The A-is-zero rule outranks the B-is-zero rule. So (+0) − (+0) gives 0x8000, and (+0) + (−0) gives 0x8000.
- R10: While `arith_go` is 1, `spec_result` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First operand, half precision |
| op_b | input | 16 | Second operand, half precision |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| spec_result | output | 16 | Decided result when no arithmetic is needed |
| arith_go | output | 1 | High when the arithmetic datapath must compute |

## Verification
The block holds no state, so a wrong internal decision shows at the ports for the same input vector that caused it.

- A misclassified operand (for instance, a power of two taken for zero) shows up as a dropped start flag, or as a special result where arithmetic was expected.
- A wrong priority order shows up only on pairs that match two rules at once, such as two zeros, NaN against infinity, or infinity against zero.

For this reason the sweep covers every pairing of the operand kinds, under both operation selects.

// File: rtl/hp_sc_pkg.sv
package hp_sc_pkg;
    localparam int EXP_W  = 5;
    localparam int FRAC_W = 10;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    // one-hot kind vector bit positions
    localparam int K_ZERO = 0;
    localparam int K_SUB  = 1;
    localparam int K_NORM = 2;
    localparam int K_INF  = 3;
    localparam int K_NAN  = 4;
    localparam int K_N    = 5;

    typedef logic [K_N-1:0] kind_t;
endpackage

// File: rtl/hp_classify.sv
module hp_classify
    import hp_sc_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [EW+FW:0] word,
    output kind_t          kind
);
    localparam logic [EW-1:0] EXP_TOP = {EW{1'b1}};

    typedef struct packed {
        kind_t kind;
    } cls_t;

    cls_t cls_d;
    logic [EW-1:0] expo;
    logic          frac_nz;

    assign expo    = word[EW+FW-1:FW];
    assign frac_nz = |word[FW-1:0];

    always_comb begin
        cls_d = '0;
        if (expo == '0) begin
            cls_d.kind[K_ZERO] = !frac_nz;
            cls_d.kind[K_SUB]  = frac_nz;
        end else if (expo == EXP_TOP) begin
            cls_d.kind[K_INF]  = !frac_nz;
            cls_d.kind[K_NAN]  = frac_nz;
        end else begin
            cls_d.kind[K_NORM] = 1'b1;
        end
    end

    assign kind = cls_d.kind;

    always_comb begin
        if (!$isunknown(word)) begin
            // R1
            kind_onehot_chk: assert ($countones(kind) == 1);
        end
    end
endmodule

// File: rtl/hp_sign_fold.sv
module hp_sign_fold
    import hp_sc_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] raw,
    input  logic         sub,
    output logic [W-1:0] eff
);
    assign eff = {raw[W-1] ^ sub, raw[W-2:0]};
endmodule

// File: rtl/hp_special_pick.sv
module hp_special_pick
    import hp_sc_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [EW+FW:0] a_word,
    input  logic [EW+FW:0] b_word,
    input  kind_t          a_kind,
    input  kind_t          b_kind,
    output logic [EW+FW:0] value,
    output logic           go
);
    localparam int W = EW + FW + 1;
    localparam logic [W-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

    typedef struct packed {
        logic [W-1:0] value;
        logic         go;
    } pick_t;

    pick_t res_d;

    always_comb begin
        res_d = '0;
        if (a_kind[K_NAN] || b_kind[K_NAN]) begin
            res_d.value = QNAN;
        end else if (a_kind[K_INF] && b_kind[K_INF]) begin
            res_d.value = (a_word[W-1] == b_word[W-1]) ? a_word : QNAN;
        end else if (a_kind[K_INF]) begin
            res_d.value = a_word;
        end else if (b_kind[K_INF]) begin
            res_d.value = b_word;
        end else if (a_kind[K_ZERO]) begin
            res_d.value = b_word;
        end else if (b_kind[K_ZERO]) begin
            res_d.value = a_word;
        end else begin
            res_d.go = 1'b1;
        end
    end

    assign value = res_d.value;
    assign go    = res_d.go;

    always_comb begin
        if (!$isunknown({a_word, b_word})) begin
            // R4
            nan_quiet_chk: assert (!(a_kind[K_NAN] || b_kind[K_NAN]) || (value == QNAN && !go));
            // R10
            idle_result_chk: assert (!go || value == '0);
            // R6
            inf_pass_chk: assert (!(a_kind[K_INF] && !b_kind[K_INF] && !b_kind[K_NAN]) || value == a_word);
        end
    end
endmodule

// File: rtl/hp_special_front.sv
module hp_special_front
    import hp_sc_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [EW+FW:0] op_a,
    input  logic [EW+FW:0] op_b,
    input  logic           op_sub,
    output logic [EW+FW:0] spec_result,
    output logic           arith_go
);
    localparam int W = EW + FW + 1;

    logic [W-1:0] b_eff;
    kind_t        a_kind;
    kind_t        b_kind;

    hp_sign_fold #(.W(W)) u_fold (
        .raw(op_b), .sub(op_sub), .eff(b_eff)
    );

    hp_classify #(.EW(EW), .FW(FW)) u_cls_a (.word(op_a),  .kind(a_kind));
    hp_classify #(.EW(EW), .FW(FW)) u_cls_b (.word(b_eff), .kind(b_kind));

    hp_special_pick #(.EW(EW), .FW(FW)) u_pick (
        .a_word(op_a), .b_word(b_eff), .a_kind(a_kind), .b_kind(b_kind),
        .value(spec_result), .go(arith_go)
    );

    always_comb begin
        if (!$isunknown({op_a, op_b, op_sub})) begin
            // R2
            go_regular_chk: assert (!arith_go ||
                ((a_kind[K_NORM] || a_kind[K_SUB]) && (b_kind[K_NORM] || b_kind[K_SUB])));
        end
    end
endmodule

// File: tb/sim_hp_special_front.sv
module sim_hp_special_front;
    logic        clk = 1'b0;
    logic [15:0] op_a, op_b;
    logic        op_sub;
    logic [15:0] spec_result;
    logic        arith_go;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    hp_special_front u0 (
        .op_a(op_a), .op_b(op_b), .op_sub(op_sub),
        .spec_result(spec_result), .arith_go(arith_go)
    );

    function automatic logic [15:0] sample(int idx);
        logic [4:0] ex [5] = '{5'd0, 5'd1, 5'd15, 5'd30, 5'd31};
        logic [9:0] fr [4] = '{10'h000, 10'h001, 10'h200, 10'h3FF};
        return {idx[0] ? 1'b1 : 1'b0, ex[idx / 8], fr[(idx / 2) % 4]};
    endfunction

    // kind: 0 zero, 1 subnormal, 2 normal, 3 inf, 4 nan
    function automatic int kind_of(logic [15:0] v);
        if (v[14:10] == 5'd0)  return (v[9:0] == 0) ? 0 : 1;
        if (v[14:10] == 5'd31) return (v[9:0] == 0) ? 3 : 4;
        return 2;
    endfunction

    task automatic check(string tag, logic [15:0] exp_s, logic exp_go);
        n_run++;
        if (arith_go !== exp_go || spec_result !== exp_s) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h sub=%b: got s=%h go=%b, expected s=%h go=%b",
                     tag, op_a, op_b, op_sub, spec_result, arith_go, exp_s, exp_go);
        end
    endtask

    task automatic apply(logic [15:0] a, logic [15:0] b, logic sub);
        @(negedge clk);
        op_a = a; op_b = b; op_sub = sub;
        #1;
    endtask

    initial begin
        op_a = 0; op_b = 0; op_sub = 0;
        // directed cases
        apply(16'h3C00, 16'h4000, 1'b0); check("R1 power-of-two normal", 16'h0000, 1'b1);
        apply(16'h0000, 16'h3C00, 1'b1); check("R3 zero minus one", 16'hBC00, 1'b0);
        apply(16'h0000, 16'h0000, 1'b1); check("R9 zero minus zero", 16'h8000, 1'b0);
        apply(16'h0000, 16'h8000, 1'b0); check("R9 pos zero plus neg zero", 16'h8000, 1'b0);
        apply(16'h7C00, 16'h7C00, 1'b1); check("R5 inf minus inf", 16'h7E00, 1'b0);
        apply(16'h7C00, 16'hFC00, 1'b1); check("R6 inf minus neg inf", 16'h7C00, 1'b0);
        apply(16'h4000, 16'h0000, 1'b1); check("R8 b zero", 16'h4000, 1'b0);
        apply(16'h0001, 16'h0200, 1'b1); check("R2 two subnormals", 16'h0000, 1'b1);

        // exhaustive sweep over representative operands
        for (int sub = 0; sub < 2; sub++) begin
            for (int i = 0; i < 40; i++) begin
                for (int j = 0; j < 40; j++) begin
                    logic [15:0] a, b, be, es;
                    logic eg;
                    int ka, kb;
                    string tag;
                    a = sample(i); b = sample(j);
                    be = {b[15] ^ sub[0], b[14:0]};
                    ka = kind_of(a); kb = kind_of(be);
                    es = 16'h0000; eg = 1'b0;
                    if (ka == 4 || kb == 4) begin
                        es = 16'h7E00; tag = "R4";
                    end else if (ka == 3 && kb == 3) begin
                        es = (a[15] == be[15]) ? a : 16'h7E00;
                        tag = (a[15] == be[15]) ? "R6" : "R5";
                    end else if (ka == 3) begin
                        es = a; tag = "R6";
                    end else if (kb == 3) begin
                        es = be; tag = sub ? "R3/R6" : "R6";
                    end else if (ka == 0) begin
                        es = be; tag = (kb == 0) ? "R9" : (sub ? "R3/R7" : "R7");
                    end else if (kb == 0) begin
                        es = a; tag = "R8";
                    end else begin
                        eg = 1'b1; tag = "R1/R2/R10";
                    end
                    apply(a, b, sub[0]);
                    check(tag, es, eg);
                end
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule